// File: doc/BRIEF.md
# Three-State Power Mode Sequencer

This block sequences a small processor subsystem through three operating modes: full operation, a stopped-CPU mode in which interrupt monitoring stays alive, and a deep low-power mode in which all on-chip activity is shut down. Software asks to enter the stopped or deep modes through request inputs. Enabled interrupts bring the subsystem back from the stopped mode. A dedicated wake input brings it back from the deep mode. A power-fault input forces the deep mode from anywhere.

Every move between modes takes its own number of clock cycles, each set by a parameter. Entering the stopped mode and leaving it are short. Entering the deep mode is moderate. Leaving the deep mode is by far the longest. While a move is under way a busy flag is high and further requests are dropped. The reported mode, the clock enables, the core power enable and a coarse power-class code are all derived from the settled mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Out of a synchronous reset the block reports mode RUN with busy low, both clock enables high, core power high and power class HIGH.
- R2: The mode code is 2'b00 for RUN, 2'b01 for IDLE and 2'b10 for SLEEP. The power class code is 2'b10 (HIGH) in RUN, 2'b01 (LOW) in IDLE and 2'b00 (MICRO) in SLEEP.
- R3: In RUN with no fault and no sleep request, a sampled `req_idle` raises busy on the next cycle. Busy then stays high for exactly LAT_RUN_IDLE cycles, after which the mode becomes IDLE.
- R4: In IDLE, any bit set in both `irq` and `irq_en` starts a move to RUN lasting LAT_IDLE_RUN cycles. An interrupt whose enable bit is clear has no effect.
- R5: `req_sleep` in RUN or IDLE starts a move to SLEEP lasting LAT_SLEEP_IN cycles. In RUN a sleep request wins over a simultaneous idle request. In IDLE an enabled interrupt wins over a simultaneous sleep request.
- R6: In SLEEP only `wake` is honoured and starts a move to RUN lasting LAT_WAKE cycles. Interrupts do not wake the block. `wake` has no effect in RUN or IDLE.
- R7: While busy, `req_idle`, `req_sleep`, interrupts and `wake` are ignored, and busy falls only when the running count expires.
- R8: `pfault` outside SLEEP starts a move to SLEEP lasting LAT_SLEEP_IN cycles. A `pfault` during a move whose destination is not SLEEP restarts the count with LAT_SLEEP_IN toward SLEEP. While `pfault` is high in SLEEP, `wake` is ignored.
- R9: `cpu_clk_en` is high only in RUN. `sys_clk_en` is high in RUN and IDLE. `core_pwr_en` is high except in SLEEP when no wake move is under way.
- R10: The reported mode holds the source mode for the whole move and changes only in the cycle where busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_idle | input | 1 | Software request to stop the CPU |
| req_sleep | input | 1 | Software request for deep low-power mode |
| irq | input | IRQ_W | Interrupt lines |
| irq_en | input | IRQ_W | Per-line interrupt enables |
| wake | input | 1 | Wake event for leaving deep mode |
| pfault | input | 1 | Power-fault indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| sys_clk_en | output | 1 | Clock enable for interrupt logic and peripherals |
| core_pwr_en | output | 1 | Core power-domain enable |
| mode | output | 2 | Settled mode code |
| pwr_class | output | 2 | Coarse power class of the settled mode |
| busy | output | 1 | A mode move is in progress |

## Verification
A request, interrupt, wake or fault is sampled at a rising edge. Busy is visible right after that edge, and the new mode appears exactly the move's latency later, in the cycle where busy falls. The enables and the power class follow the mode with no further register. The bench drives inputs and samples outputs on falling edges. Its behavioural model advances on the same rising edges, so each comparison lands in the cycle where a result is due. Separate counters measure each move's busy length against its latency parameter, including a fault that restarts a move partway through.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10
    } pm_mode_e;

    typedef enum logic [1:0] {
        PC_MICRO = 2'b00,
        PC_LOW   = 2'b01,
        PC_HIGH  = 2'b10
    } pm_class_e;

    typedef struct packed {
        logic     go;
        pm_mode_e dest;
    } pm_move_t;

    typedef struct packed {
        logic      cpu_clk;
        logic      sys_clk;
        logic      core_pwr;
        pm_class_e pclass;
    } pm_drive_t;

    function automatic pm_class_e class_of(input pm_mode_e m);
        case (m)
            PM_RUN:  return PC_HIGH;
            PM_IDLE: return PC_LOW;
            default: return PC_MICRO;
        endcase
    endfunction

endpackage

// File: rtl/pmc_arbiter.sv
module pmc_arbiter
    import pmc_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  pm_mode_e           cur,
    input  logic               busy,
    input  pm_mode_e           tgt,
    input  logic               req_idle,
    input  logic               req_sleep,
    input  logic [IRQ_W-1:0]   irq,
    input  logic [IRQ_W-1:0]   irq_en,
    input  logic               wake,
    input  logic               pfault,
    output pm_move_t           move
);

    logic irq_hit;

    assign irq_hit = |(irq & irq_en);

    always_comb begin
        move.go   = 1'b0;
        move.dest = PM_RUN;
        if (busy) begin
            if (pfault && tgt != PM_SLEEP) begin
                move.go   = 1'b1;
                move.dest = PM_SLEEP;
            end
        end else begin
            case (cur)
                PM_RUN: begin
                    if (pfault || req_sleep) begin
                        move.go   = 1'b1;
                        move.dest = PM_SLEEP;
                    end else if (req_idle) begin
                        move.go   = 1'b1;
                        move.dest = PM_IDLE;
                    end
                end
                PM_IDLE: begin
                    if (pfault) begin
                        move.go   = 1'b1;
                        move.dest = PM_SLEEP;
                    end else if (irq_hit) begin
                        move.go   = 1'b1;
                        move.dest = PM_RUN;
                    end else if (req_sleep) begin
                        move.go   = 1'b1;
                        move.dest = PM_SLEEP;
                    end
                end
                default: begin
                    if (wake && !pfault) begin
                        move.go   = 1'b1;
                        move.dest = PM_RUN;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pmc_timer.sv
module pmc_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == {{(CW-1){1'b0}}, 1'b1});

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt_q == $past(load_val)); // R7

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R7

endmodule

// File: rtl/pmc_outdec.sv
module pmc_outdec
    import pmc_pkg::*;
(
    input  pm_mode_e  cur,
    input  logic      busy,
    input  pm_mode_e  tgt,
    output pm_drive_t drv
);

    always_comb begin
        drv.cpu_clk  = (cur == PM_RUN);
        drv.sys_clk  = (cur != PM_SLEEP);
        drv.core_pwr = (cur != PM_SLEEP) || (busy && tgt == PM_RUN);
        drv.pclass   = class_of(cur);
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int IRQ_W        = 8,
    parameter int LAT_RUN_IDLE = 10,
    parameter int LAT_IDLE_RUN = 10,
    parameter int LAT_SLEEP_IN = 90,
    parameter int LAT_WAKE     = 1600
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_idle,
    input  logic             req_sleep,
    input  logic [IRQ_W-1:0] irq,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             wake,
    input  logic             pfault,
    output logic             cpu_clk_en,
    output logic             sys_clk_en,
    output logic             core_pwr_en,
    output logic [1:0]       mode,
    output logic [1:0]       pwr_class,
    output logic             busy
);

    localparam int LAT_MAX_A = (LAT_RUN_IDLE > LAT_IDLE_RUN) ? LAT_RUN_IDLE : LAT_IDLE_RUN;
    localparam int LAT_MAX_B = (LAT_SLEEP_IN > LAT_WAKE) ? LAT_SLEEP_IN : LAT_WAKE;
    localparam int LAT_MAX   = (LAT_MAX_A > LAT_MAX_B) ? LAT_MAX_A : LAT_MAX_B;
    localparam int CW        = $clog2(LAT_MAX + 1);

    localparam logic [CW-1:0] L_RI = CW'(LAT_RUN_IDLE);
    localparam logic [CW-1:0] L_IR = CW'(LAT_IDLE_RUN);
    localparam logic [CW-1:0] L_SI = CW'(LAT_SLEEP_IN);
    localparam logic [CW-1:0] L_WK = CW'(LAT_WAKE);

    pm_mode_e      mode_q;
    pm_mode_e      tgt_q;
    logic          busy_q;
    pm_move_t      move;
    logic [CW-1:0] lat_val;
    logic          expire;
    pm_drive_t     drv;

    pmc_arbiter #(.IRQ_W(IRQ_W)) u_arb (
        .cur       (mode_q),
        .busy      (busy_q),
        .tgt       (tgt_q),
        .req_idle  (req_idle),
        .req_sleep (req_sleep),
        .irq       (irq),
        .irq_en    (irq_en),
        .wake      (wake),
        .pfault    (pfault),
        .move      (move)
    );

    always_comb begin
        case (move.dest)
            PM_IDLE:  lat_val = L_RI;
            PM_SLEEP: lat_val = L_SI;
            default:  lat_val = (mode_q == PM_IDLE) ? L_IR : L_WK;
        endcase
    end

    pmc_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (move.go),
        .load_val (lat_val),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_RUN;
            tgt_q  <= PM_RUN;
            busy_q <= 1'b0;
        end else if (move.go) begin
            tgt_q  <= move.dest;
            busy_q <= 1'b1;
        end else if (busy_q && expire) begin
            mode_q <= tgt_q;
            busy_q <= 1'b0;
        end
    end

    pmc_outdec u_dec (
        .cur  (mode_q),
        .busy (busy_q),
        .tgt  (tgt_q),
        .drv  (drv)
    );

    assign cpu_clk_en  = drv.cpu_clk;
    assign sys_clk_en  = drv.sys_clk;
    assign core_pwr_en = drv.core_pwr;
    assign pwr_class   = drv.pclass;
    assign mode        = mode_q;
    assign busy        = busy_q;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11); // R2

    AST_MODE_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> ($past(busy_q) && !busy_q)); // R10

    AST_FAULT_HEADS_DOWN: assert property (@(posedge clk) disable iff (rst)
        pfault |=> ((busy_q && tgt_q == PM_SLEEP) || (mode_q == PM_SLEEP && !busy_q))); // R8

    AST_SLEEP_NEEDS_WAKE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_SLEEP && !busy_q && !wake) |=> !busy_q); // R6

    AST_SLEEP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_SLEEP) |-> (!cpu_clk_en && !sys_clk_en)); // R9

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !expire) |=> busy_q); // R7

endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;

    localparam int IW  = 4;
    localparam int LRI = 4;
    localparam int LIR = 5;
    localparam int LS  = 9;
    localparam int LW  = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_idle = 1'b0, req_sleep = 1'b0, wake = 1'b0, pfault = 1'b0;
    logic [IW-1:0] irq = '0, irq_en = '0;
    logic          cpu_clk_en, sys_clk_en, core_pwr_en, busy;
    logic [1:0]    mode, pwr_class;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    pwr_mode_ctrl #(
        .IRQ_W(IW), .LAT_RUN_IDLE(LRI), .LAT_IDLE_RUN(LIR),
        .LAT_SLEEP_IN(LS), .LAT_WAKE(LW)
    ) uut (
        .clk(clk), .rst(rst), .req_idle(req_idle), .req_sleep(req_sleep),
        .irq(irq), .irq_en(irq_en), .wake(wake), .pfault(pfault),
        .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .core_pwr_en(core_pwr_en),
        .mode(mode), .pwr_class(pwr_class), .busy(busy)
    );

    always #4 clk = ~clk;

    // behavioural reference: mode 0 run, 1 idle, 2 sleep
    int m_mode = 0, m_tgt = 0, m_left = 0;
    bit m_busy = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_tgt = 0; m_left = 0; m_busy = 1'b0;
        end else if (m_busy) begin
            if (pfault && m_tgt != 2) begin
                m_tgt = 2; m_left = LS;
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_mode = m_tgt; m_busy = 1'b0;
                end
            end
        end else if (m_mode == 0) begin
            if (pfault || req_sleep) begin m_tgt = 2; m_left = LS; m_busy = 1'b1; end
            else if (req_idle) begin m_tgt = 1; m_left = LRI; m_busy = 1'b1; end
        end else if (m_mode == 1) begin
            if (pfault) begin m_tgt = 2; m_left = LS; m_busy = 1'b1; end
            else if ((irq & irq_en) != 0) begin m_tgt = 0; m_left = LIR; m_busy = 1'b1; end
            else if (req_sleep) begin m_tgt = 2; m_left = LS; m_busy = 1'b1; end
        end else begin
            if (wake && !pfault) begin m_tgt = 0; m_left = LW; m_busy = 1'b1; end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(mode == 2'(m_mode), "R10", "mode", int'(mode), m_mode);
            check(busy == m_busy, "R7", "busy", int'(busy), int'(m_busy));
            check(cpu_clk_en == (m_mode == 0), "R9", "cpu_clk_en", int'(cpu_clk_en), int'(m_mode == 0));
            check(sys_clk_en == (m_mode != 2), "R9", "sys_clk_en", int'(sys_clk_en), int'(m_mode != 2));
            check(core_pwr_en == ((m_mode != 2) || (m_busy && m_tgt == 0)), "R9", "core_pwr_en",
                  int'(core_pwr_en), int'((m_mode != 2) || (m_busy && m_tgt == 0)));
            check(pwr_class == ((m_mode == 0) ? 2'b10 : (m_mode == 1) ? 2'b01 : 2'b00), "R2",
                  "pwr_class", int'(pwr_class), (m_mode == 0) ? 2 : (m_mode == 1) ? 1 : 0);
        end
    end

    // one-cycle pulse; entered and left on a falling edge
    task automatic drive(input bit ri, input bit rs, input bit wk, input bit pf, input logic [IW-1:0] iq);
        req_idle = ri; req_sleep = rs; wake = wk; pfault = pf; irq = iq;
        @(negedge clk);
        req_idle = 1'b0; req_sleep = 1'b0; wake = 1'b0; pfault = 1'b0; irq = '0;
    endtask

    task automatic measure(input int exp_len, input int exp_mode, input string req, input bit noise);
        int n = 0;
        while (busy && n < 100000) begin
            n++;
            if (noise && n == 3) begin req_idle = 1'b1; req_sleep = 1'b1; irq = '1; wake = 1'b1; end
            if (noise && n == 7) begin req_idle = 1'b0; req_sleep = 1'b0; irq = '0; wake = 1'b0; end
            @(negedge clk);
        end
        check(n == exp_len, req, "busy length", n, exp_len);
        check(mode == 2'(exp_mode), req, "settled mode", int'(mode), exp_mode);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(mode == 2'b00 && !busy, "R1", "mode/busy", {mode, busy}, 0);
        check(cpu_clk_en && sys_clk_en && core_pwr_en && pwr_class == 2'b10, "R1", "enables/class",
              {cpu_clk_en, sys_clk_en, core_pwr_en, pwr_class}, 5'b11110);

        // R6: wake in RUN ignored
        drive(0, 0, 1, 0, '0);
        check(!busy && mode == 2'b00, "R6", "wake in run", int'(busy), 0);

        // R3: RUN -> IDLE
        drive(1, 0, 0, 0, '0);
        measure(LRI, 1, "R3", 0);

        // R4: masked interrupt and idle request in IDLE ignored
        irq_en = 4'b0100;
        drive(1, 0, 0, 0, 4'b0011);
        check(!busy && mode == 2'b01, "R4", "masked irq", int'(busy), 0);

        // R4: enabled interrupt IDLE -> RUN
        drive(0, 0, 0, 0, 4'b0100);
        measure(LIR, 0, "R4", 0);

        // R5: sleep beats idle in RUN
        drive(1, 1, 0, 0, '0);
        measure(LS, 2, "R5", 0);

        // R6: interrupt in SLEEP ignored
        drive(0, 0, 0, 0, 4'b0100);
        check(!busy && mode == 2'b10, "R6", "irq in sleep", int'(busy), 0);

        // R6 + R7: wake, with requests during the move ignored
        drive(0, 0, 1, 0, '0);
        measure(LW, 0, "R7", 1);

        // R5: enabled interrupt beats sleep in IDLE
        drive(1, 0, 0, 0, '0);
        measure(LRI, 1, "R3", 0);
        drive(0, 1, 0, 0, 4'b0100);
        measure(LIR, 0, "R5", 0);

        // R8: fault preempts RUN -> IDLE move
        drive(1, 0, 0, 0, '0);
        @(negedge clk);
        drive(0, 0, 0, 1, '0);
        measure(LS, 2, "R8", 0);

        // R8: wake ignored while fault held in SLEEP
        pfault = 1'b1; wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        check(!busy && mode == 2'b10, "R8", "wake under fault", int'(busy), 0);
        pfault = 1'b0;
        @(negedge clk);

        // R8: fault during wake move restarts toward SLEEP
        drive(0, 0, 1, 0, '0);
        repeat (3) @(negedge clk);
        drive(0, 0, 0, 1, '0);
        measure(LS, 2, "R8", 0);

        // R6: final wake back to RUN
        drive(0, 0, 1, 0, '0);
        measure(LW, 0, "R6", 0);

        // R8: fault from IDLE
        drive(1, 0, 0, 0, '0);
        measure(LRI, 1, "R3", 0);
        drive(0, 0, 0, 1, '0);
        measure(LS, 2, "R8", 0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule